// File: doc/BRIEF.md
# Transfer Activation Enable Bank

This block decides which interrupt sources are allowed to start a data-transfer engine. Software programs 48 per-source enable bits, held as six byte-wide registers, plus one software-activation register that carries an activation flag and a 7-bit vector number. Every source that is both pending and enabled is turned into a request towards the engine. Sources are served lowest index first. The software activation counts as the last and lowest-priority source.

The engine reports each finished transfer on a completion stream. Each report carries the source index, that transfer's disable-interrupt flag and a flag saying that the programmed count has run out. From these the block clears enable bits by itself. A 16-bit block-transfer counter counts block transfers down, and when it reaches zero the block has ended. The software-activation flag is guarded: a 0 written to it only takes effect after software has read it back as 1.

The request output is a valid/ready stream. Once `req_valid` is high, `req_src`, `req_sw` and `req_vec` stay fixed until the engine raises `req_ready`. A served source is not requested again until its completion report arrives. The completion stream never applies back-pressure: `done_ready` is held high and a report is taken in every cycle in which `done_valid` is high.

Top module: `trig_enable_bank`

## Requirements
- R1: After reset, and after any cycle with `stby` high, all six enable registers and the software-activation register read 0x00.
- R2: CPU addresses 0 to 5 select the enable registers. Bit b of the register at address r is the enable for source 8r+b (1 enables, 0 disables). A write is visible on `cpu_rdata` from the next cycle.
- R3: Address 6 is the software-activation register, with the flag in bit 7 and the vector in bits 6:0. A write of bit 7 = 1 always sets the flag. A write of bit 7 = 0 clears it only if a read of address 6 has returned the flag as 1 since the previous write to address 6. Every write consumes that qualification.
- R4: A completion report with the disable flag at 0, the count not ended and the block not ended leaves every enable bit unchanged.
- R5: A completion report with the disable flag at 1 clears the enable of the reported source. Source index 48 stands for the software-activation flag.
- R6: A completion report with `done_last` at 1 clears the enable of the reported source, whatever the value of the disable flag.
- R7: The block counter is written through addresses 8 (low byte) and 9 (high byte) and read back there. Each completion report with `done_blk` at 1 decrements the counter. The report that takes it from 1 to 0 pulses `blk_end` in the same cycle and clears the source's enable. A loaded 0 stands for 65,536 transfers.
- R8: When a CPU write and a hardware clear hit the same enable bit in the same cycle, the bit ends at 0.
- R9: A request is issued only for a source that is both pending and enabled. Among such sources the lowest index goes first, and the software activation (index 48, `req_sw` = 1) goes last.
- R10: While `req_valid` is high and `req_ready` is low, the request fields hold. A source that has been served is not requested again until a completion report for it has been accepted.
- R11: `done_ready` is 1 at all times, so every completion report is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stby | input | 1 | Hardware standby: clears the enable and software registers |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (qualifies the software flag) |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| src_pend | input | 48 | Per-source pending activation |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_src | output | 6 | Requested source index (48 = software) |
| req_sw | output | 1 | Request is the software activation |
| req_vec | output | 7 | Software vector captured with the request |
| done_valid | input | 1 | Completion report valid |
| done_ready | output | 1 | Completion report ready (always 1) |
| done_src | input | 6 | Source index of the finished transfer |
| done_disel | input | 1 | Disable-interrupt flag of that transfer |
| done_last | input | 1 | Programmed transfer count has ended |
| done_blk | input | 1 | Report counts against the block counter |
| blk_end | output | 1 | Block counter reached zero on this report |

## Verification
A stuck or wrongly cleared enable bit shows on the next read of its register, one cycle after the completion report. It also shows in the request order, because a source that is missing or extra in the ordered request sequence reveals the error as soon as it is served. A lost busy mark shows as a duplicate request on the cycle after the source is served. A wrong counter value shows as a `blk_end` pulse on the wrong report, and an unguarded software flag shows as a cleared bit 7 on the read that follows the write.

// File: rtl/trig_en_pkg.sv
package trig_en_pkg;
  // default geometry of the bank
  localparam int DEF_NUM_REGS = 6;
  localparam int DEF_REG_W    = 8;
  localparam int DEF_CNT_W    = 16;
  localparam int DEF_ADDR_W   = 4;
  localparam int DEF_SRC_W    = 6;
  // first CPU address of the block counter bytes
  localparam int CNT_BASE     = 8;
endpackage

// File: rtl/trig_en_regfile.sv
module trig_en_regfile #(
  parameter int NUM_REGS = 6,
  parameter int REG_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             stby,
  input  logic [NUM_REGS-1:0]              wr_reg_sel,
  input  logic                             wr_sw,
  input  logic                             rd_sw,
  input  logic [REG_W-1:0]                 wdata,
  input  logic [NUM_REGS*REG_W-1:0]        hw_clr,
  input  logic                             hw_clr_sw,
  output logic [NUM_REGS-1:0][REG_W-1:0]   en_r,
  output logic                             swen,
  output logic [REG_W-2:0]                 swvec,
  output logic                             sw_seen
);
  localparam int VEC_W = REG_W - 1;

  // one byte-wide enable register per slice; hardware clear dominates
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n || stby) begin
        en_r[r] <= '0;
      end else begin
        en_r[r] <= (wr_reg_sel[r] ? wdata : en_r[r]) & ~hw_clr[r*REG_W +: REG_W];
      end
    end
  end

  logic swen_nx;
  always_comb begin
    swen_nx = swen;
    if (wr_sw) begin
      if (wdata[REG_W-1])  swen_nx = 1'b1;
      else if (sw_seen)    swen_nx = 1'b0;
    end
    if (hw_clr_sw) swen_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stby) begin
      swen    <= 1'b0;
      swvec   <= '0;
      sw_seen <= 1'b0;
    end else begin
      swen <= swen_nx;
      if (wr_sw) begin
        swvec   <= wdata[VEC_W-1:0];
        sw_seen <= 1'b0;
      end else if (rd_sw && swen) begin
        sw_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_blk_counter.sv
module trig_blk_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W/BYTE_W-1:0]     wr_byte,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        dec,
  output logic [CNT_W-1:0]            cnt,
  output logic                        end_now
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_nx;
  logic             any_wr;

  assign any_wr  = |wr_byte;
  // a CPU load in the same cycle takes precedence over the decrement
  assign end_now = dec && !any_wr && (cnt == CNT_W'(1));

  always_comb begin
    cnt_nx = cnt;
    if (any_wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_byte[b]) cnt_nx[b*BYTE_W +: BYTE_W] = wdata;
      end
    end else if (dec) begin
      cnt_nx = cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/trig_req_arb.sv
module trig_req_arb #(
  parameter int NREQ  = 49,
  parameter int IDX_W = 6,
  parameter int VEC_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    pend,
  input  logic [NREQ-1:0]    en,
  input  logic [VEC_W-1:0]   sw_vec,
  input  logic               req_ready,
  input  logic               done_fire,
  input  logic [IDX_W-1:0]   done_idx,
  output logic               req_valid,
  output logic [IDX_W-1:0]   req_idx,
  output logic [VEC_W-1:0]   req_vec
);
  logic [NREQ-1:0]  busy, busy_nx, slot_mask, cand;
  logic [IDX_W-1:0] sel;
  logic             any;
  logic             fire, open;

  assign fire = req_valid && req_ready;
  assign open = !req_valid || req_ready;

  always_comb begin
    slot_mask = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_valid && req_idx == IDX_W'(i)) slot_mask[i] = 1'b1;
    end
  end

  assign cand = pend & en & ~busy & ~slot_mask;

  // fixed priority: scanning downward leaves the lowest index selected
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    busy_nx = busy;
    for (int i = 0; i < NREQ; i++) begin
      if (fire && req_idx == IDX_W'(i))       busy_nx[i] = 1'b1;
      if (done_fire && done_idx == IDX_W'(i)) busy_nx[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      req_valid <= 1'b0;
      req_idx   <= '0;
      req_vec   <= '0;
    end else begin
      busy <= busy_nx;
      if (open) begin
        req_valid <= any;
        if (any) begin
          req_idx <= sel;
          req_vec <= sw_vec;
        end
      end
    end
  end
endmodule

// File: rtl/trig_enable_bank.sv
module trig_enable_bank
  import trig_en_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int REG_W    = DEF_REG_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int SRC_W    = DEF_SRC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        stby,
  input  logic                        cpu_wr,
  input  logic                        cpu_rd,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [REG_W-1:0]            cpu_wdata,
  output logic [REG_W-1:0]            cpu_rdata,
  input  logic [NUM_REGS*REG_W-1:0]   src_pend,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [SRC_W-1:0]            req_src,
  output logic                        req_sw,
  output logic [REG_W-2:0]            req_vec,
  input  logic                        done_valid,
  output logic                        done_ready,
  input  logic [SRC_W-1:0]            done_src,
  input  logic                        done_disel,
  input  logic                        done_last,
  input  logic                        done_blk,
  output logic                        blk_end
);
  localparam int NSRC   = NUM_REGS * REG_W;
  localparam int NREQ   = NSRC + 1;
  localparam int VEC_W  = REG_W - 1;
  localparam int NBYTES = CNT_W / REG_W;
  localparam int A_SW   = NUM_REGS;

  logic [NUM_REGS-1:0][REG_W-1:0] en_r;
  logic [NSRC-1:0]                en_vec;
  logic                           swen, sw_seen;
  logic [VEC_W-1:0]               swvec;
  logic [NUM_REGS-1:0]            wr_reg_sel;
  logic                           wr_sw, rd_sw;
  logic [NBYTES-1:0]              wr_cnt;
  logic [CNT_W-1:0]               cnt;
  logic                           done_fire, clr_cond;
  logic [NREQ-1:0]                hw_clr_ext;

  assign done_ready = 1'b1;
  assign done_fire  = done_valid;
  assign en_vec     = en_r;

  // ---------------- address decode ----------------
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_wsel
    assign wr_reg_sel[r] = cpu_wr && (cpu_addr == ADDR_W'(r));
  end
  for (genvar b = 0; b < NBYTES; b++) begin : g_csel
    assign wr_cnt[b] = cpu_wr && (cpu_addr == ADDR_W'(CNT_BASE + b));
  end
  assign wr_sw = cpu_wr && (cpu_addr == ADDR_W'(A_SW));
  assign rd_sw = cpu_rd && (cpu_addr == ADDR_W'(A_SW));

  // ---------------- completion-driven clearing ----------------
  assign clr_cond = done_fire && (done_disel || done_last || blk_end);

  always_comb begin
    hw_clr_ext = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (clr_cond && done_src == SRC_W'(i)) hw_clr_ext[i] = 1'b1;
    end
  end

  trig_en_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby      (stby),
    .wr_reg_sel(wr_reg_sel),
    .wr_sw     (wr_sw),
    .rd_sw     (rd_sw),
    .wdata     (cpu_wdata),
    .hw_clr    (hw_clr_ext[NSRC-1:0]),
    .hw_clr_sw (hw_clr_ext[NSRC]),
    .en_r      (en_r),
    .swen      (swen),
    .swvec     (swvec),
    .sw_seen   (sw_seen)
  );

  trig_blk_counter #(.CNT_W(CNT_W), .BYTE_W(REG_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_byte(wr_cnt),
    .wdata  (cpu_wdata),
    .dec    (done_fire && done_blk),
    .cnt    (cnt),
    .end_now(blk_end)
  );

  trig_req_arb #(.NREQ(NREQ), .IDX_W(SRC_W), .VEC_W(VEC_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     ({swen, src_pend}),
    .en       ({swen, en_vec}),
    .sw_vec   (swvec),
    .req_ready(req_ready),
    .done_fire(done_fire),
    .done_idx (done_src),
    .req_valid(req_valid),
    .req_idx  (req_src),
    .req_vec  (req_vec)
  );

  assign req_sw = (req_src == SRC_W'(NSRC));

  // ---------------- read mux ----------------
  always_comb begin
    cpu_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (cpu_addr == ADDR_W'(r)) cpu_rdata = en_r[r];
    end
    if (cpu_addr == ADDR_W'(A_SW)) cpu_rdata = {swen, swvec};
    for (int b = 0; b < NBYTES; b++) begin
      if (cpu_addr == ADDR_W'(CNT_BASE + b)) cpu_rdata = cnt[b*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/trig_enable_bank_chk.sv
module trig_enable_bank_chk #(
  parameter int NSRC   = 48,
  parameter int SRC_W  = 6,
  parameter int ADDR_W = 4,
  parameter int REG_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stby,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [REG_W-1:0]  cpu_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SRC_W-1:0]  req_src,
  input logic [REG_W-2:0]  req_vec,
  input logic              done_valid,
  input logic [SRC_W-1:0]  done_src,
  input logic              done_disel,
  input logic              done_last,
  input logic              blk_end,
  input logic [NSRC-1:0]   en_vec,
  input logic              swen,
  input logic              sw_seen,
  input logic [CNT_W-1:0]  cnt
);
  logic [NSRC:0] en_d;
  always_ff @(posedge clk) begin
    if (!rst_n) en_d <= '0;
    else        en_d <= {swen, en_vec};
  end

  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (en_vec == '0 && !swen)); // R1

  AST_SWEN_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == ADDR_W'(NSRC / REG_W) && !cpu_wdata[REG_W-1] && !sw_seen
     && swen && !done_valid && !stby) |=> swen); // R3

  AST_KEEP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_disel && !done_last && !blk_end && !cpu_wr && !stby)
      |=> $stable(en_vec)); // R4

  AST_DISEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_disel && int'(done_src) < NSRC) |=> !en_vec[$past(done_src)]); // R5

  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_last && int'(done_src) < NSRC) |=> !en_vec[$past(done_src)]); // R6

  AST_BLK_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> (cnt == '0)); // R7

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && int'(req_src) <= NSRC) |-> en_d[req_src]); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_vec))); // R10
endmodule

bind trig_enable_bank trig_enable_bank_chk #(
  .NSRC(NUM_REGS*REG_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stby(stby), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
  .req_vec(req_vec), .done_valid(done_valid), .done_src(done_src), .done_disel(done_disel),
  .done_last(done_last), .blk_end(blk_end), .en_vec(en_vec), .swen(swen),
  .sw_seen(sw_seen), .cnt(cnt)
);

// File: tb/trig_enable_bank_test.sv
`timescale 1ns/1ps
module trig_enable_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, stby = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic [47:0] src_pend = '0;
  logic        req_valid, req_ready = 1'b0, req_sw;
  logic [5:0]  req_src;
  logic [6:0]  req_vec;
  logic        done_valid = 1'b0, done_ready;
  logic [5:0]  done_src = '0;
  logic        done_disel = 1'b0, done_last = 1'b0, done_blk = 1'b0;
  logic        blk_end;

  int checks = 0, errors = 0;
  logic [13:0] expq[$];   // {sw, src[5:0], vec[6:0]}

  always #2.5 clk = ~clk;

  trig_enable_bank uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rdchk(input logic [3:0] a, input int exp, input string req);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    #1 chk(req, $sformatf("read addr %0d", a), cpu_rdata, exp);
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic cpl(input int src, input bit dis, input bit last, input bit blk, input bit exp_end);
    @(negedge clk);
    done_valid = 1'b1; done_src = 6'(src); done_disel = dis; done_last = last; done_blk = blk;
    #1 chk("R7", $sformatf("blk_end on report for %0d", src), blk_end, exp_end);
    @(negedge clk);
    done_valid = 1'b0; done_disel = 1'b0; done_last = 1'b0; done_blk = 1'b0;
  endtask

  task automatic push(input bit sw, input int src, input int vec);
    expq.push_back({sw, 6'(src), 7'(vec)});
  endtask

  // scoreboard monitor: every accepted request must match the next expected one
  always @(negedge clk) begin
    #1;
    if (rst_n && req_valid && req_ready) begin
      if (expq.size() == 0) begin
        chk("R9", "unexpected request source", req_src, 99);
      end else begin
        logic [13:0] e;
        e = expq.pop_front();
        chk("R9", "request source order", req_src, e[12:7]);
        chk("R9", "request software flag", req_sw, e[13]);
        if (e[13]) chk("R3", "software vector", req_vec, e[6:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("R10", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R11: reset state
    for (int a = 0; a <= 6; a++) rdchk(4'(a), 0, "R1");
    chk("R11", "done_ready", done_ready, 1);
    chk("R10", "no request after reset", req_valid, 0);

    // R2: program and read back
    wr(4'd0, 8'hA5);
    wr(4'd5, 8'h81);
    rdchk(4'd0, 8'hA5, "R2");
    rdchk(4'd5, 8'h81, "R2");

    // R9/R10: pending 0,1,2,5,40,47; source 1 disabled
    @(negedge clk);
    src_pend = 48'h0;
    src_pend[0] = 1'b1; src_pend[1] = 1'b1; src_pend[2] = 1'b1;
    src_pend[5] = 1'b1; src_pend[40] = 1'b1; src_pend[47] = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R10", "held valid under back-pressure", req_valid, 1);
    chk("R10", "held source under back-pressure", req_src, 0);
    push(0, 0, 0); push(0, 2, 0); push(0, 5, 0); push(0, 40, 0); push(0, 47, 0);
    @(negedge clk); req_ready = 1'b1;
    repeat (10) @(negedge clk);
    req_ready = 1'b0; src_pend = '0;
    chk("R10", "served each source once", expq.size(), 0);

    // R4: keep-enable completions
    cpl(0, 0, 0, 0, 0);
    cpl(5, 0, 0, 0, 0);
    rdchk(4'd0, 8'hA5, "R4");
    // R5: disable flag clears
    cpl(2, 1, 0, 0, 0);
    rdchk(4'd0, 8'hA1, "R5");
    // R6: count ended clears
    cpl(40, 0, 1, 0, 0);
    rdchk(4'd5, 8'h80, "R6");

    // R7: block counter of 3 on source 47
    wr(4'd8, 8'd3);
    wr(4'd9, 8'd0);
    cpl(47, 0, 0, 1, 0);
    rdchk(4'd8, 2, "R7");
    rdchk(4'd5, 8'h80, "R7");
    cpl(47, 0, 0, 1, 0);
    cpl(47, 0, 0, 1, 1);
    rdchk(4'd5, 8'h00, "R7");
    rdchk(4'd8, 0, "R7");
    // R7: a loaded zero means 65536
    cpl(47, 0, 0, 1, 0);
    rdchk(4'd9, 8'hFF, "R7");
    rdchk(4'd8, 8'hFF, "R7");

    // R8: CPU write and hardware clear on the same bit
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 4'd0; cpu_wdata = 8'hFF;
    done_valid = 1'b1; done_src = 6'd0; done_disel = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; done_valid = 1'b0; done_disel = 1'b0;
    rdchk(4'd0, 8'hFE, "R8");

    // R3: software activation register
    wr(4'd6, 8'h00);
    rdchk(4'd6, 8'h00, "R3");
    wr(4'd6, 8'h85);
    push(1, 48, 5);
    rdchk(4'd6, 8'h85, "R3");
    wr(4'd6, 8'h05);
    rdchk(4'd6, 8'h05, "R3");
    @(negedge clk); req_ready = 1'b1;
    repeat (2) @(negedge clk);
    req_ready = 1'b0;
    wr(4'd6, 8'h8A);
    wr(4'd6, 8'h0A);
    rdchk(4'd6, 8'h8A, "R3");
    wr(4'd6, 8'h0B);
    rdchk(4'd6, 8'h0B, "R3");
    // R5 on the software flag (index 48)
    wr(4'd6, 8'h81);
    cpl(48, 1, 0, 0, 0);
    rdchk(4'd6, 8'h01, "R5");
    repeat (3) @(negedge clk);
    chk("R10", "no request while released source idle", req_valid, 0);

    // R1: standby clears
    wr(4'd3, 8'h33);
    rdchk(4'd3, 8'h33, "R2");
    @(negedge clk); stby = 1'b1;
    @(negedge clk); stby = 1'b0;
    rdchk(4'd3, 8'h00, "R1");
    rdchk(4'd0, 8'h00, "R1");

    chk("R9", "all expected requests seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule